// File: doc/BRIEF.md
# Load Switch Enable and Timeout Controller

This block is the digital controller for one load switch. Software sets an enable bit, an auto-discharge bit and a two-bit wait-time field in a small control register. The block then drives the switch gate only while two upstream supply converters are both enabled and both report power good. When either converter drops out, the switch goes off at once. It comes back by itself when both converters return, provided the enable bit is still set.

A watchdog timed by a 1 µs tick guards every turn-on. If the switch output has not reached its input when the wait time expires, the switch is shut off and held off. A current limit that stays active for a full wait time does the same. A held-off switch comes back only after software writes a 1 to the enable bit again. The same register shows read-only flags for timeout, overcurrent, overtemperature and output power good. An overload event pulses when the current limit engages. The discharge path, when allowed, is active only while the switch is off.

Top module: `load_switch_ctrl`

## Requirements
- R1: `gate_en` goes high one clock after the enable bit (register bit 0) is 1 and all four upstream inputs `conv_a_en`, `conv_a_pg`, `conv_b_en`, `conv_b_pg` are 1. With any of the five at 0 it stays low.
- R2: When any upstream input falls, `gate_en` falls on the next clock edge. When all four return with the enable bit still 1, `gate_en` rises again on the next clock edge, with no software action.
- R3: Each rise of `gate_en` starts a startup watchdog. If `out_at_in` is 0 when the watchdog expires, `gate_en` falls on the expiry edge and the timeout flag (register bit 4) is set. With ticks on every cycle, `gate_en` stays high for exactly the wait time counted in clocks.
- R4: After startup, the watchdog restarts from zero whenever `ilim_active` rises, and is cleared whenever `ilim_active` falls. If the limit is held for a full wait time (the gate then reads high for wait−1 samples after the limit appears), the switch trips as in R3. Shorter bursts do not trip it.
- R5: Register bits [3:2] select the wait time as the base time (parameter `BASE_US`, default 200) multiplied by 1, 4, 8 or 16 for codes 00, 01, 10, 11.
- R6: After a trip, the switch stays off whatever the upstream state, until a register write carries bit 0 = 1. This applies even if the enable bit is already 1. That write clears the timeout flag, and the gate rises on the following edge.
- R7: The power-good flag (register bit 7) follows `out_above_80`, with one clock of delay.
- R8: While `ilim_active` is 1 and the switch is on, the overcurrent flag (register bit 5) reads 1, one clock later. `ovl_event` pulses high for one clock when that flag rises.
- R9: `dis_en` equals the auto-discharge bit (register bit 1) ANDed with the switch being off. It is never high while `gate_en` is high.
- R10: After reset, `rd_data` reads 0x02: auto-discharge on, enable off, wait code 00, all flags clear. Writes change only bits [3:0].
- R11: While `over_temp` is 1, `gate_en` is low (falling on the next edge) and the overtemperature flag (register bit 6) reads 1. When it clears, the switch resumes if every other condition holds.
- R12: The watchdog advances only on clock cycles where `tick_us` is 1. With a tick every second cycle, the startup time doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data; bits [3:0] are stored |
| rd_data | output | 8 | Control register and status flags |
| conv_a_en | input | 1 | Upstream converter A enabled |
| conv_a_pg | input | 1 | Upstream converter A power good |
| conv_b_en | input | 1 | Upstream converter B enabled |
| conv_b_pg | input | 1 | Upstream converter B power good |
| out_at_in | input | 1 | Switch output has reached its input |
| out_above_80 | input | 1 | Switch output above 80 % of input |
| ilim_active | input | 1 | Analog current limit is regulating |
| over_temp | input | 1 | Switch overtemperature |
| gate_en | output | 1 | Switch gate enable |
| dis_en | output | 1 | Output discharge enable |
| ovl_event | output | 1 | One-cycle overload event |

## Verification
The bench sweeps all sixteen upstream combinations and each of the four wait codes. For every wait code it counts the exact number of cycles the gate stays high before a startup trip, so a wrong shift in the wait decoder or an off-by-one in the expiry compare shows up as a wrong count. It re-arms the switch with a write of 1 while the enable bit is already 1, and checks that nothing else revives it. A design that re-arms only on a 0-to-1 change of the bit would leave the switch dead. It also sends current-limit bursts one tick short of the wait time: a counter that is not cleared between bursts would trip the switch wrongly. Running with ticks on every other cycle catches a counter that runs free on the clock.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    // Control fields, bit 0 upward: enable, auto-discharge, wait select
    typedef struct packed {
        logic [1:0] wait_sel;
        logic       auto_dis;
        logic       enable;
    } lsw_ctrl_t;

    // Read-only status flags, bit 4 upward
    typedef struct packed {
        logic pwr_good;
        logic over_temp;
        logic over_cur;
        logic timed_out;
    } lsw_flags_t;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_START = 2'd1,
        WD_RUN   = 2'd2
    } wd_mode_e;

    localparam logic [3:0] CTRL_RESET = 4'h2;

    // Multiplier exponent for the wait code: x1, x4, x8, x16
    function automatic int unsigned wait_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/lsw_regs.sv
module lsw_regs
    import lsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_bits,
    input  logic       trip_now,
    input  logic       gate_q,
    input  logic       over_temp,
    input  logic       ilim_active,
    input  logic       out_above_80,
    output lsw_ctrl_t  ctrl,
    output lsw_flags_t flags,
    output logic       ovl_event,
    output logic [7:0] rd_data
);

    lsw_ctrl_t ctrl_q;
    logic      tripped_q;
    logic      ot_q;
    logic      oc_q;
    logic      pg_q;
    logic      ovl_q;
    logic      rearm;
    logic      oc_d;

    assign rearm = wr_en & wr_bits[0];
    assign oc_d  = ilim_active & gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= lsw_ctrl_t'(CTRL_RESET);
        end else if (wr_en) begin
            ctrl_q <= lsw_ctrl_t'(wr_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tripped_q <= 1'b0;
        end else if (trip_now) begin
            tripped_q <= 1'b1;
        end else if (rearm) begin
            tripped_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ot_q  <= 1'b0;
            oc_q  <= 1'b0;
            pg_q  <= 1'b0;
            ovl_q <= 1'b0;
        end else begin
            ot_q  <= over_temp;
            oc_q  <= oc_d;
            pg_q  <= out_above_80;
            ovl_q <= oc_d & ~oc_q;
        end
    end

    always_comb begin
        ctrl            = ctrl_q;
        flags.timed_out = tripped_q;
        flags.over_cur  = oc_q;
        flags.over_temp = ot_q;
        flags.pwr_good  = pg_q;
    end

    assign ovl_event = ovl_q;
    assign rd_data   = {flags, ctrl_q};

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_q && !rearm) |=> tripped_q);

    // R8
    ovl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ovl_q |=> !ovl_q);

    // R8
    ovl_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_q) |-> ovl_q);

endmodule

// File: rtl/lsw_watchdog.sv
module lsw_watchdog
    import lsw_pkg::*;
#(
    parameter int unsigned BASE_US = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic [1:0] wait_sel,
    input  logic       start,
    input  logic       gate_q,
    input  logic       out_at_in,
    input  logic       ilim_active,
    output logic       trip_now
);

    localparam int unsigned MAX_LIM = BASE_US * 16;
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

    wd_mode_e         mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             running;
    logic             expire;
    logic             startup_fail;

    always_comb begin
        lim          = CNT_W'(BASE_US) << wait_shift(wait_sel);
        running      = (mode_q == WD_START) | ((mode_q == WD_RUN) & ilim_active);
        expire       = running & tick_us & (cnt_q >= lim - CNT_W'(1));
        startup_fail = (mode_q == WD_START) & ~out_at_in;
        trip_now     = expire & (startup_fail | ilim_active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WD_OFF;
            cnt_q  <= '0;
        end else if (start) begin
            mode_q <= WD_START;
            cnt_q  <= '0;
        end else if (!gate_q || trip_now) begin
            mode_q <= WD_OFF;
            cnt_q  <= '0;
        end else if (expire) begin
            mode_q <= WD_RUN;
            cnt_q  <= '0;
        end else if (running) begin
            if (tick_us) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_LIM));

    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_us && !start && gate_q && running) |=> $stable(cnt_q));

    // R3
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_q && !start) |=> (mode_q == WD_OFF));

endmodule

// File: rtl/lsw_gate.sv
module lsw_gate (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic auto_dis,
    input  logic conv_a_en,
    input  logic conv_a_pg,
    input  logic conv_b_en,
    input  logic conv_b_pg,
    input  logic tripped,
    input  logic trip_now,
    input  logic over_temp,
    output logic gate_q,
    output logic gate_rise,
    output logic dis_en
);

    logic up_ok;
    logic gate_d;

    always_comb begin
        up_ok     = conv_a_en & conv_a_pg & conv_b_en & conv_b_pg;
        gate_d    = enable & up_ok & ~tripped & ~trip_now & ~over_temp;
        gate_rise = gate_d & ~gate_q;
        dis_en    = auto_dis & ~gate_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // R1
    interlock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> $past(up_ok && enable));

    // R2
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        !up_ok |=> !gate_q);

    // R9
    discharge_chk: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> !dis_en);

    // R11
    hot_off_chk: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> !gate_q);

    // R3
    trip_off_chk: assert property (@(posedge clk) disable iff (rst)
        trip_now |=> !gate_q);

endmodule

// File: rtl/load_switch_ctrl.sv
module load_switch_ctrl
    import lsw_pkg::*;
#(
    parameter int unsigned BASE_US = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       conv_a_en,
    input  logic       conv_a_pg,
    input  logic       conv_b_en,
    input  logic       conv_b_pg,
    input  logic       out_at_in,
    input  logic       out_above_80,
    input  logic       ilim_active,
    input  logic       over_temp,
    output logic       gate_en,
    output logic       dis_en,
    output logic       ovl_event
);

    lsw_ctrl_t  ctrl;
    lsw_flags_t flags;
    logic       gate_q;
    logic       gate_rise;
    logic       trip_now;
    logic       unused_wr_hi;

    // Upper write bits address read-only flags and are dropped
    assign unused_wr_hi = ^wr_data[7:4];

    lsw_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_bits      (wr_data[3:0]),
        .trip_now     (trip_now),
        .gate_q       (gate_q),
        .over_temp    (over_temp),
        .ilim_active  (ilim_active),
        .out_above_80 (out_above_80),
        .ctrl         (ctrl),
        .flags        (flags),
        .ovl_event    (ovl_event),
        .rd_data      (rd_data)
    );

    lsw_watchdog #(
        .BASE_US (BASE_US)
    ) u_wdog (
        .clk         (clk),
        .rst         (rst),
        .tick_us     (tick_us),
        .wait_sel    (ctrl.wait_sel),
        .start       (gate_rise),
        .gate_q      (gate_q),
        .out_at_in   (out_at_in),
        .ilim_active (ilim_active),
        .trip_now    (trip_now)
    );

    lsw_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.enable),
        .auto_dis  (ctrl.auto_dis),
        .conv_a_en (conv_a_en),
        .conv_a_pg (conv_a_pg),
        .conv_b_en (conv_b_en),
        .conv_b_pg (conv_b_pg),
        .tripped   (flags.timed_out),
        .trip_now  (trip_now),
        .over_temp (over_temp),
        .gate_q    (gate_q),
        .gate_rise (gate_rise),
        .dis_en    (dis_en)
    );

    assign gate_en = gate_q;

    // R6
    no_revive_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.timed_out && !(wr_en && wr_data[0])) |=> !gate_en);

    // R10
    wr_ro_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[3:0] == $past(wr_data[3:0])));

endmodule

// File: tb/tb_load_switch_ctrl.sv
module tb_load_switch_ctrl;

    localparam int unsigned BASE = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       a_en = 1'b0, a_pg = 1'b0, b_en = 1'b0, b_pg = 1'b0;
    logic       out_at_in = 1'b1;
    logic       out_above_80 = 1'b0;
    logic       ilim = 1'b0;
    logic       hot = 1'b0;
    logic       gate_en, dis_en, ovl_event;
    logic       tick_alt = 1'b0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    load_switch_ctrl #(.BASE_US(BASE)) dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .conv_a_en(a_en), .conv_a_pg(a_pg), .conv_b_en(b_en), .conv_b_pg(b_pg),
        .out_at_in(out_at_in), .out_above_80(out_above_80),
        .ilim_active(ilim), .over_temp(hot),
        .gate_en(gate_en), .dis_en(dis_en), .ovl_event(ovl_event)
    );

    // Ticks on every cycle, or every other cycle when tick_alt is set
    always @(negedge clk) begin
        if (tick_alt) tick_us <= ~tick_us;
        else          tick_us <= 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_up(input logic [3:0] v);
        {a_en, a_pg, b_en, b_pg} = v;
    endtask

    // Counts negedge samples with the gate high until it falls
    task automatic count_high(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (gate_en) n++;
            else if (n > 0) break;
        end
    endtask

    function automatic int lim_of(input int code);
        int sh;
        sh = (code == 0) ? 0 : code + 1;
        return BASE << sh;
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset rd_data", rd_data, 8'h02);
        chk("R10 reset gate", gate_en, 0);
        chk("R9 reset discharge", dis_en, 1);
        chk("R8 reset event", ovl_event, 0);

        // R1 / R2 sweep of upstream states with enable set
        wr(8'h03);
        for (int v = 0; v < 16; v++) begin
            set_up(4'(v));
            @(negedge clk);
            chk($sformatf("R1 gate upstream=%0h", v), gate_en, (v == 15) ? 1 : 0);
            chk($sformatf("R9 discharge upstream=%0h", v), dis_en, (v == 15) ? 0 : 1);
            set_up(4'hF);
            @(negedge clk);
            chk($sformatf("R2 auto return from %0h", v), gate_en, 1);
        end
        // R1 enable clear keeps switch off
        wr(8'h02);
        @(negedge clk);
        chk("R1 enable off", gate_en, 0);
        // R10 upper bits ignored on write
        wr(8'hF2);
        chk("R10 ro bits", rd_data, 8'h02);

        // R3 / R5 startup timeout for every wait code
        out_at_in = 1'b0;
        for (int c = 0; c < 4; c++) begin
            wr(8'(c << 2) | 8'h03);
            count_high(n);
            chk($sformatf("R5 R3 wait code %0d cycles", c), n, lim_of(c));
            chk($sformatf("R3 timeout flag code %0d", c), rd_data[4], 1);
            // R6 upstream cycling does not revive
            set_up(4'h0);
            @(negedge clk);
            set_up(4'hF);
            repeat (3) @(negedge clk);
            chk($sformatf("R6 stays off code %0d", c), gate_en, 0);
            wr(8'h02);
        end

        // R6 re-arm with 1 while enable already 1
        wr(8'h03);
        count_high(n);
        chk("R3 trip before rearm", rd_data[4], 1);
        out_at_in = 1'b1;
        wr(8'h03);
        chk("R6 flag cleared", rd_data[4], 0);
        @(negedge clk);
        chk("R6 gate back", gate_en, 1);
        repeat (BASE + 3) @(negedge clk);
        chk("R3 output reached keeps on", gate_en, 1);

        // R4 short limit bursts do not trip
        for (int k = 0; k < 3; k++) begin
            ilim = 1'b1;
            repeat (BASE - 1) @(negedge clk);
            ilim = 1'b0;
            @(negedge clk);
        end
        chk("R4 short bursts", gate_en, 1);
        // R8 overcurrent flag and event
        ilim = 1'b1;
        @(negedge clk);
        chk("R8 oc flag", rd_data[5], 1);
        chk("R8 event", ovl_event, 1);
        @(negedge clk);
        chk("R8 event one cycle", ovl_event, 0);
        ilim = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 oc clear", rd_data[5], 0);
        // R4 sustained limit trips
        ilim = 1'b1;
        count_high(n);
        chk("R4 sustained limit samples", n, BASE - 1);
        chk("R4 timeout flag", rd_data[4], 1);
        ilim = 1'b0;
        wr(8'h03);
        @(negedge clk);

        // R7 power good follows comparator
        out_above_80 = 1'b1;
        @(negedge clk);
        chk("R7 pg set", rd_data[7], 1);
        out_above_80 = 1'b0;
        @(negedge clk);
        chk("R7 pg clear", rd_data[7], 0);

        // R11 overtemperature
        chk("R11 on before", gate_en, 1);
        hot = 1'b1;
        @(negedge clk);
        chk("R11 gate off", gate_en, 0);
        chk("R11 flag", rd_data[6], 1);
        hot = 1'b0;
        @(negedge clk);
        chk("R11 resume", gate_en, 1);

        // R9 discharge disabled by bit
        wr(8'h00);
        @(negedge clk);
        chk("R9 no discharge when bit clear", dis_en, 0);

        // R12 half-rate tick doubles startup time
        out_at_in = 1'b0;
        tick_alt  = 1'b1;
        wr(8'h01);
        count_high(n);
        chk("R12 half tick window", (n >= 2*BASE-1 && n <= 2*BASE+1) ? 1 : 0, 1);
        tick_alt = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule